// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Condition Flags

This block is a purely combinational arithmetic logic unit of parameterized width. It is built from a row of identical one-bit slices. Each slice conditions its two operand bits and picks its output through a small multiplexer. The slices share one ripple-carry chain for addition. A 4-bit control word produces five operations: bitwise AND, bitwise OR, add, subtract and NOR. Alongside the result word, the unit reports four condition flags: zero, sign, carry and signed overflow.

The control word is treated as three fields. Bit 3 complements operand A before it reaches the slices. Bit 2 complements operand B and also injects a carry of 1 into the lowest slice, so the adder computes A + ~B + 1. Bits 1:0 pick what each slice outputs. Only five control values are legal. Every other value yields an all-zero result.

The unit has no clock, reset, handshake or storage. It is placed wherever a datapath needs a single-cycle arithmetic or logical step, and its outputs settle within the same evaluation as its inputs.

Top module: `bsalu_core`

## Requirements
- R1: Control 4'b0000 gives result = A & B for every bit.
- R2: Control 4'b0001 gives result = A | B for every bit.
- R3: Control 4'b0010 gives result = (A + B) mod 2^W.
- R4: Control 4'b0110 gives result = (A - B) mod 2^W, computed as A + ~B + 1.
- R5: Control 4'b1100 gives result = ~(A | B), obtained as (~A) & (~B).
- R6: Any control value other than 0000, 0001, 0010, 0110 and 1100 gives an all-zero result. The flags then read zero=1, sign=0, carry=0 and overflow=0.
- R7: flag_zero is 1 exactly when every result bit is 0.
- R8: flag_sign equals the most significant result bit.
- R9: For add and subtract, flag_carry is the carry out of the top slice. For subtract this means 1 when A >= B as unsigned numbers. For all other control values, flag_carry is 0.
- R10: For add and subtract, flag_ovf is 1 exactly when the two's-complement result overflows, taken as the XOR of the carry into and the carry out of the top slice. For all other control values, flag_ovf is 0.
- R11: The carry ripples through every slice, so a carry born in slice 0 can reach the top slice and the carry flag; for example, all-ones + 1 gives 0 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| ctrl | input | 4 | Operation control: invert A, negate B, slice select[1:0] |
| result | output | WIDTH | Operation result |
| flag_zero | output | 1 | Result is all zeros |
| flag_sign | output | 1 | Most significant result bit |
| flag_carry | output | 1 | Carry out of top slice (add/subtract only) |
| flag_ovf | output | 1 | Signed overflow (add/subtract only) |

## Verification
The bench targets the following corner cases, each paired with the failure it would catch:

- **Full carry ripple.** All-ones plus one must wrap to zero with the carry flag set. A broken chain link would leave a stray 1 in the result or drop the carry.
- **Subtraction carry.** Subtracting with a borrow, such as 0 - 1, must clear the carry flag, while A >= B must set it. A design that forgets the injected carry would be off by one. One that inverts the carry sense would swap these cases.
- **Signed overflow.** Positive plus positive giving a negative, and most-negative minus one, must raise the overflow flag. Overflow rules taken from operand signs alone would misfire when the signs differ on subtract.
- **Illegal control codes.** Codes such as 0011, 0111 and 1111 are applied with non-zero operands. A design that decodes only the select bits would leak a sum or a stale carry instead of a zero result.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_RSVD = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       inv_a;
    logic       neg_b;
    slice_sel_e sel;
  } alu_ctrl_t;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/bsalu_decode.sv
module bsalu_decode
  import bsalu_pkg::*;
(
  input  logic [3:0] ctrl,
  output alu_ctrl_t  fields,
  output logic       legal,
  output logic       arith
);
  always_comb begin
    fields.inv_a = ctrl[3];
    fields.neg_b = ctrl[2];
    fields.sel   = slice_sel_e'(ctrl[1:0]);
    unique case (ctrl)
      CODE_AND, CODE_OR, CODE_NOR: begin
        legal = 1'b1;
        arith = 1'b0;
      end
      CODE_ADD, CODE_SUB: begin
        legal = 1'b1;
        arith = 1'b1;
      end
      default: begin
        legal = 1'b0;
        arith = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
  import bsalu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       inv_a,
  input  logic       neg_b,
  input  slice_sel_e sel,
  input  logic       c_in,
  output logic       r_bit,
  output logic       c_out
);
  logic a_eff, b_eff, sum_bit;

  always_comb begin
    a_eff   = a_bit ^ inv_a;
    b_eff   = b_bit ^ neg_b;
    sum_bit = a_eff ^ b_eff ^ c_in;
    c_out   = (a_eff & b_eff) | (c_in & (a_eff ^ b_eff));
    unique case (sel)
      SEL_AND: r_bit = a_eff & b_eff;
      SEL_OR:  r_bit = a_eff | b_eff;
      SEL_SUM: r_bit = sum_bit;
      default: r_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic             c_top_in,
  input  logic             c_top_out,
  input  logic             arith,
  output logic             zero,
  output logic             sign,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    zero  = ~|res;
    sign  = res[MSB];
    carry = arith & c_top_out;
    ovf   = arith & (c_top_in ^ c_top_out);
  end
endmodule

// File: rtl/bsalu_core.sv
module bsalu_core
  import bsalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] result,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_carry,
  output logic             flag_ovf
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        fields;
  logic             legal;
  logic             arith;
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] raw;

  bsalu_decode u_dec (
    .ctrl   (ctrl),
    .fields (fields),
    .legal  (legal),
    .arith  (arith)
  );

  assign chain[0] = fields.neg_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bsalu_slice u_slice (
      .a_bit (op_a[i]),
      .b_bit (op_b[i]),
      .inv_a (fields.inv_a),
      .neg_b (fields.neg_b),
      .sel   (fields.sel),
      .c_in  (chain[i]),
      .r_bit (raw[i]),
      .c_out (chain[i+1])
    );
  end

  assign result = legal ? raw : '0;

  bsalu_flags #(.WIDTH(WIDTH)) u_flags (
    .res       (result),
    .c_top_in  (chain[MSB]),
    .c_top_out (chain[WIDTH]),
    .arith     (arith),
    .zero      (flag_zero),
    .sign      (flag_sign),
    .carry     (flag_carry),
    .ovf       (flag_ovf)
  );
endmodule

// File: rtl/bsalu_core_chk.sv
module bsalu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       ctrl,
  input logic [WIDTH-1:0] result,
  input logic             flag_zero,
  input logic             flag_sign,
  input logic             flag_carry,
  input logic             flag_ovf
);
  logic is_legal, is_arith;

  always_comb begin
    is_legal = (ctrl == 4'b0000) || (ctrl == 4'b0001) || (ctrl == 4'b0010) ||
               (ctrl == 4'b0110) || (ctrl == 4'b1100);
    is_arith = (ctrl == 4'b0010) || (ctrl == 4'b0110);

    // R1
    and_result_chk: assert (ctrl != 4'b0000 || result == (op_a & op_b));
    // R5
    nor_result_chk: assert (ctrl != 4'b1100 || result == ~(op_a | op_b));
    // R6
    illegal_zero_chk: assert (is_legal || (result == '0 && flag_zero));
    // R7
    zero_flag_chk: assert (flag_zero == (result == '0));
    // R8
    sign_flag_chk: assert (flag_sign == result[WIDTH-1]);
    // R9
    logic_carry_chk: assert (is_arith || !flag_carry);
    // R10
    logic_ovf_chk: assert (is_arith || !flag_ovf);
  end
endmodule

bind bsalu_core bsalu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .ctrl       (ctrl),
  .result     (result),
  .flag_zero  (flag_zero),
  .flag_sign  (flag_sign),
  .flag_carry (flag_carry),
  .flag_ovf   (flag_ovf)
);

// File: tb/bsalu_core_tb_top.sv
module bsalu_core_tb_top;
  localparam int W = 32;
  localparam int NV = 16;

  // each entry: {ctrl[3:0], a[31:0], b[31:0]}
  localparam logic [67:0] VEC [NV] = '{
    {4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00},
    {4'b0001, 32'hF000_0001, 32'h0000_F002},
    {4'b0010, 32'h1234_5678, 32'h1111_1111},
    {4'b0010, 32'hFFFF_0000, 32'h0001_0000},
    {4'b0110, 32'h0000_0010, 32'h0000_0003},
    {4'b0110, 32'h0000_0005, 32'h0000_0009},
    {4'b1100, 32'hA5A5_0000, 32'h0000_5A5A},
    {4'b1100, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'b0011, 32'h1234_5678, 32'h8765_4321},
    {4'b0111, 32'hFFFF_FFFF, 32'h0000_0001},
    {4'b1111, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {4'b1000, 32'h0000_FFFF, 32'hFFFF_0000},
    {4'b0100, 32'h7777_7777, 32'h1111_1111},
    {4'b1110, 32'h0000_0001, 32'h0000_0001},
    {4'b0010, 32'h8000_0000, 32'h8000_0000},
    {4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] op_a, op_b, result;
  logic [3:0]   ctrl;
  logic         flag_zero, flag_sign, flag_carry, flag_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bsalu_core #(.WIDTH(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .ctrl(ctrl), .result(result),
    .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
  );

  function automatic logic [35:0] model(input logic [3:0] c, input logic [W-1:0] a,
                                        input logic [W-1:0] b);
    logic [W:0] wide;
    logic [W-1:0] r;
    logic cy, ov;
    cy = 1'b0; ov = 1'b0; r = '0;
    case (c)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b1100: r = ~(a | b);
      4'b0010: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0]; cy = wide[W];
        ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'b0110: begin
        wide = {1'b0, a} + {1'b0, ~b} + 1;
        r = wide[W-1:0]; cy = (a >= b);
        ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      default: r = '0;
    endcase
    return {r, (r == '0), r[W-1], cy, ov};
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b1100: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag);
    logic [35:0] exp;
    @(negedge clk);
    ctrl = c; op_a = a; op_b = b;
    #2;
    exp = model(c, a, b);
    checks++;
    if ({result, flag_zero, flag_sign, flag_carry, flag_ovf} !== exp) begin
      errors++;
      $display("FAIL %s/R7/R8/R9/R10 ctrl=%b a=%h b=%h got r=%h z%b s%b c%b v%b exp r=%h z%b s%b c%b v%b",
               tag, c, a, b, result, flag_zero, flag_sign, flag_carry, flag_ovf,
               exp[35:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    ctrl = 4'b0000; op_a = '0; op_b = '0;
    // reset-like idle state: zero inputs, AND -> zero result, zero flag (R7)
    run(4'b0000, '0, '0, "R7");
    for (int i = 0; i < NV; i++)
      run(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0], tag_of(VEC[i][67:64]));
    // R11 full ripple: all ones + 1
    run(4'b0010, 32'hFFFF_FFFF, 32'h0000_0001, "R11");
    // R10 positive overflow on add
    run(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001, "R10");
    // R9 borrow: 0 - 1 clears carry
    run(4'b0110, 32'h0000_0000, 32'h0000_0001, "R9");
    // R10 most negative minus one overflows
    run(4'b0110, 32'h8000_0000, 32'h0000_0001, "R10");
    // R9 equal operands: carry set, result zero
    run(4'b0110, 32'h5555_AAAA, 32'h5555_AAAA, "R9");
    // R8 sign from msb on OR
    run(4'b0001, 32'h8000_0000, 32'h0000_0000, "R8");
    // R6 illegal code with carry-generating operands
    run(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule